// File: doc/BRIEF.md
# Serial Control Word Register Port

This block is a write-only configuration port. A host loads a bank of 9-bit control registers by sending 16-bit words. The upper seven bits of each word name the register and the lower nine bits are the new value. The block holds the register bank itself and presents every register on one flat output bus. Downstream logic slices that bus to pick up its settings.

A static mode input picks one of two serial front ends, and both share the same three pins. The first is a three-wire shift interface: an active-low select, a shift clock and a data line. The second is a two-wire I2C-style slave that owns a fixed device address, takes writes only and answers through an open-drain pull-down output.

The bus clock and the data line pass through a two-stage synchroniser and are then sampled by the system clock. Writing any value to register address 0 returns the whole bank to its defaults.

Top module: `ctrl_word_port`

## Requirements
- R1: While reset is held and after it is released, register i holds its default: 0 for i = 0, and otherwise (i*37 + 5) mod 512.
- R2: A committed word writes bits [8:0] into the register whose index is in bits [15:9].
- R3: In three-wire mode (mode_2w = 0) the data line is sampled MSB first on each rising edge of the shift clock while csn_i is low. The word commits on the rising edge of csn_i only if exactly 16 bits were shifted. A frame of 15 or 17 bits changes nothing.
- R4: In two-wire mode the frame is START, then the byte {7'h1A, 0}, then a byte holding word[15:8], then a byte holding word[7:0]. Each byte is sent MSB first on rising bus clocks. After each byte the block drives sda_pull_o high (pulling the data line low) for the ninth clock pulse.
- R5: In two-wire mode, a device address other than 7'h1A, or a first byte whose bit 0 is 1 (read), gets no acknowledge, and the write is dropped.
- R6: A STOP condition before the second data byte has been acknowledged aborts the write, and no register changes.
- R7: A committed word to address 0 restores every register to its R1 default, whatever the data bits are.
- R8: A committed word whose address is 64 or above leaves every register unchanged.
- R9: Only the front end selected by mode_2w can write. sda_pull_o stays low whenever mode_2w is 0.
- R10: In two-wire mode the register changes only after the acknowledge of the second data byte ends. The target still holds its old value during that acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_2w | input | 1 | 1 selects the two-wire slave, 0 the three-wire shifter |
| csn_i | input | 1 | Three-wire select, active low |
| sclk_i | input | 1 | Shift clock (three-wire) or bus clock (two-wire) |
| sdat_i | input | 1 | Serial data as seen on the line |
| sda_pull_o | output | 1 | 1 pulls the open-drain data line low for an acknowledge |
| regs_o | output | 576 | Register i occupies bits [9*i+8 : 9*i] |

## Verification
Four relations are checked on every cycle:
- The bank is stable in every cycle without a commit.
- A commit to an ordinary address lands in the following cycle.
- A commit to address 0 restores defaults.
- A two-wire commit coincides with the release of the acknowledge, and the pull is never active in three-wire mode.

Only the bench scenarios can show the rest:
- Which frames produce a commit at all: bit counts, device address matching, read rejection and STOP aborts.
- The acknowledge seen on the line in each byte slot.
- That the traffic of the unselected interface is ignored.

// File: rtl/cwp_pkg.sv
// Package: shared sizes, the two-wire slave state type and the
// register default rule used by the register bank.
package cwp_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 9;
    localparam int WORD_W = ADDR_W + DATA_W;

    typedef enum logic [2:0] {
        TW_IDLE,
        TW_DEV,
        TW_HI,
        TW_LO,
        TW_ACK,
        TW_SKIP
    } tw_state_t;

    // Default value of register idx: zero at index 0, arithmetic pattern elsewhere.
    function automatic logic [DATA_W-1:0] reg_default(input int unsigned idx);
        int unsigned v;
        if (idx == 0) return '0;
        v = (idx * 37 + 5) % (1 << DATA_W);
        return v[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/cwp_sync.sv
// Module: cwp_sync
// Brings WIDTH asynchronous lines into the clk domain through two flops.
// Assumes the lines are slow compared with clk; the reset value models idle lines.
module cwp_sync #(
    parameter int          WIDTH    = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1;

    // Two-flop synchroniser with idle-level reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/cwp_shift3.sv
// Module: cwp_shift3
// Three-wire receiver: shifts data MSB first on rising shift-clock edges
// while select is low, and emits a one-cycle commit on the select rising
// edge when exactly WORD_W bits arrived. Assumes synchronised inputs.
module cwp_shift3
    import cwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              csn_s,
    input  logic              sclk_s,
    input  logic              sdat_s,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

    logic             csn_q;
    logic             sclk_q;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] shreg;

    assign word_o = shreg;

    // Edge tracking, bit counting and frame commit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            csn_q    <= 1'b1;
            sclk_q   <= 1'b1;
            cnt      <= '0;
            shreg    <= '0;
            commit_o <= 1'b0;
        end else begin
            csn_q    <= csn_s;
            sclk_q   <= sclk_s;
            commit_o <= 1'b0;
            if (csn_s) begin
                if (!csn_q && cnt == FULL) commit_o <= 1'b1;
                cnt <= '0;
            end else if (sclk_s && !sclk_q) begin
                shreg <= {shreg[WORD_W-2:0], sdat_s};
                if (cnt != OVER) cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cwp_slave2.sv
// Module: cwp_slave2
// Two-wire write-only slave: detects START/STOP, matches the device address
// with a write bit, takes two data bytes, acknowledges each byte by pulling
// the data line for one clock pulse, and commits once the second
// acknowledge is released. Assumes synchronised inputs and a bus clock much
// slower than clk.
module cwp_slave2
    import cwp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              pull_o,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    tw_state_t  st;
    tw_state_t  nxt;
    logic       scl_q;
    logic       sda_q;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] hi_byte;
    logic [7:0] lo_byte;
    logic       pull_q;

    logic scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl_s && !scl_q;
    assign scl_fall = !scl_s && scl_q;
    assign start_c  = scl_s && scl_q && sda_q && !sda_s;
    assign stop_c   = scl_s && scl_q && !sda_q && sda_s;
    assign pull_o   = pull_q && en_i;
    assign word_o   = {hi_byte, lo_byte};

    // Bus state machine: byte reception, acknowledge and commit.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            st       <= TW_IDLE;
            nxt      <= TW_IDLE;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            cnt      <= '0;
            shreg    <= '0;
            hi_byte  <= '0;
            lo_byte  <= '0;
            pull_q   <= 1'b0;
            commit_o <= 1'b0;
        end else begin
            scl_q    <= scl_s;
            sda_q    <= sda_s;
            commit_o <= 1'b0;
            if (start_c) begin
                st     <= TW_DEV;
                cnt    <= '0;
                pull_q <= 1'b0;
            end else if (stop_c) begin
                st     <= TW_IDLE;
                pull_q <= 1'b0;
            end else begin
                case (st)
                    TW_DEV, TW_HI, TW_LO: begin
                        if (scl_rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (st == TW_DEV) begin
                                if (shreg[7:1] == DEV_ADDR && !shreg[0]) begin
                                    pull_q <= 1'b1;
                                    nxt    <= TW_HI;
                                    st     <= TW_ACK;
                                end else begin
                                    st <= TW_SKIP;
                                end
                            end else if (st == TW_HI) begin
                                hi_byte <= shreg;
                                pull_q  <= 1'b1;
                                nxt     <= TW_LO;
                                st      <= TW_ACK;
                            end else begin
                                lo_byte <= shreg;
                                pull_q  <= 1'b1;
                                nxt     <= TW_SKIP;
                                st      <= TW_ACK;
                            end
                        end
                    end
                    TW_ACK: begin
                        if (scl_fall) begin
                            pull_q <= 1'b0;
                            st     <= nxt;
                            if (nxt == TW_SKIP) commit_o <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cwp_regbank.sv
// Module: cwp_regbank
// Register bank of NREG entries with computed defaults. A commit writes one
// entry; a commit to index 0 reloads every default; indices at or above
// NREG are dropped. Drives all entries on a flat bus.
module cwp_regbank
    import cwp_pkg::*;
#(
    parameter int NREG = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      data_i,
    output logic [NREG*DATA_W-1:0] regs_o
);
    logic [DATA_W-1:0] bank [NREG];
    logic              soft_rst;
    logic              in_range;

    assign soft_rst = wr_i && (addr_i == '0);
    assign in_range = 32'(addr_i) < NREG;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // One entry: default on reset, then direct writes by index.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                bank[g] <= reg_default(g);
            end else if (wr_i && in_range && 32'(addr_i) == g) begin
                bank[g] <= data_i;
            end
        end
        assign regs_o[g*DATA_W +: DATA_W] = bank[g];
    end
endmodule

// File: rtl/ctrl_word_port.sv
// Module: ctrl_word_port (top)
// Serial control port: synchronises the pins, runs the selected front end
// and routes its commits into the register bank. mode_2w is a static
// configuration input; changing it returns both front ends to idle.
module ctrl_word_port
    import cwp_pkg::*;
#(
    parameter int         NREG     = 64,
    parameter logic [6:0] DEV_ADDR = 7'h1A
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_2w,
    input  logic                   csn_i,
    input  logic                   sclk_i,
    input  logic                   sdat_i,
    output logic                   sda_pull_o,
    output logic [NREG*DATA_W-1:0] regs_o
);
    logic [2:0]        pins_s;
    logic              c3, c2;
    logic [WORD_W-1:0] w3, w2;
    logic              wr_en;
    logic [WORD_W-1:0] wr_word;

    cwp_sync #(.WIDTH(3), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({csn_i, sclk_i, sdat_i}), .q_o(pins_s)
    );

    cwp_shift3 u_shift3 (
        .clk(clk), .rst_n(rst_n), .en_i(!mode_2w),
        .csn_s(pins_s[2]), .sclk_s(pins_s[1]), .sdat_s(pins_s[0]),
        .commit_o(c3), .word_o(w3)
    );

    cwp_slave2 #(.DEV_ADDR(DEV_ADDR)) u_slave2 (
        .clk(clk), .rst_n(rst_n), .en_i(mode_2w),
        .scl_s(pins_s[1]), .sda_s(pins_s[0]),
        .pull_o(sda_pull_o), .commit_o(c2), .word_o(w2)
    );

    assign wr_en   = mode_2w ? c2 : c3;
    assign wr_word = mode_2w ? w2 : w3;

    cwp_regbank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_en),
        .addr_i(wr_word[WORD_W-1:DATA_W]), .data_i(wr_word[DATA_W-1:0]),
        .regs_o(regs_o)
    );
endmodule

// File: rtl/ctrl_word_port_chk.sv
// Module: ctrl_word_port_chk
// Cycle-level properties of the port, bound into every ctrl_word_port.
module ctrl_word_port_chk
    import cwp_pkg::*;
#(
    parameter int NREG = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mode_2w,
    input logic                   sda_pull_o,
    input logic                   wr_en,
    input logic [WORD_W-1:0]      wr_word,
    input logic [NREG*DATA_W-1:0] regs_o
);
    // R2: an in-range write lands one cycle later
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_word[15:9] != 0 && 32'(wr_word[15:9]) < NREG |=>
        regs_o[$past(wr_word[15:9])*DATA_W +: DATA_W] == $past(wr_word[8:0]));

    // R7: address 0 reloads defaults (first and last entries sampled)
    a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_word[15:9] == 0 |=>
        regs_o[DATA_W +: DATA_W] == reg_default(1) &&
        regs_o[(NREG-1)*DATA_W +: DATA_W] == reg_default(NREG-1));

    // R8 / R2: without a commit the bank does not move
    a_r8_stable_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

    // R9: pull-down never active in three-wire mode
    a_r9_no_pull_3w: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_2w |-> !sda_pull_o);

    // R10: a two-wire commit coincides with release of the acknowledge
    a_r10_commit_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && mode_2w |-> $fell(sda_pull_o));
endmodule

bind ctrl_word_port ctrl_word_port_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_2w(mode_2w), .sda_pull_o(sda_pull_o),
    .wr_en(wr_en), .wr_word(wr_word), .regs_o(regs_o)
);

// File: tb/ctrl_word_port_test.sv
// Bench: drives both serial front ends and compares the bank against a model.
module ctrl_word_port_test;
    localparam int NREG = 64;
    localparam int H    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_2w = 1'b0;
    logic csn = 1'b1;
    logic sclk = 1'b1;
    logic dat = 1'b1;
    logic pull;
    logic line;
    logic [NREG*9-1:0] regs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [8:0] model [NREG];

    always #2.5 clk = ~clk;

    assign line = dat & ~pull;

    ctrl_word_port uut (
        .clk(clk), .rst_n(rst_n), .mode_2w(mode_2w), .csn_i(csn),
        .sclk_i(sclk), .sdat_i(line), .sda_pull_o(pull), .regs_o(regs)
    );

    function automatic logic [8:0] dflt(input int i);
        if (i == 0) return 9'd0;
        return 9'((i * 37 + 5) % 512);
    endfunction

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++) check(req, 32'(regs[i*9 +: 9]), 32'(model[i]));
    endtask

    // Three-wire frame of nb bits, MSB first, taken from v[nb-1:0].
    task automatic w3(input int nb, input logic [31:0] v);
        csn = 1'b0; waitc(H);
        for (int b = nb - 1; b >= 0; b--) begin
            sclk = 1'b0; waitc(H);
            dat = v[b]; waitc(H);
            sclk = 1'b1; waitc(H);
        end
        sclk = 1'b0; waitc(H);
        dat = 1'b1; waitc(H);
        csn = 1'b1; waitc(H);
        sclk = 1'b1; waitc(2 * H);
    endtask

    task automatic t_start();
        dat = 1'b1; sclk = 1'b1; waitc(H);
        dat = 1'b0; waitc(H);
        sclk = 1'b0; waitc(H);
    endtask

    task automatic t_stop();
        dat = 1'b0; waitc(H);
        sclk = 1'b1; waitc(H);
        dat = 1'b1; waitc(2 * H);
    endtask

    // One byte plus acknowledge slot; optional mid-ack check of one register.
    task automatic t_byte(input logic [7:0] b, output bit acked,
                          input bit chk, input int idx, input logic [8:0] old);
        for (int k = 7; k >= 0; k--) begin
            dat = b[k]; waitc(H);
            sclk = 1'b1; waitc(H);
            sclk = 1'b0;
        end
        dat = 1'b1; waitc(H);
        sclk = 1'b1; waitc(H / 2);
        acked = !line;
        if (chk) check("R10 value held during final ack", 32'(regs[idx*9 +: 9]), 32'(old));
        waitc(H - H / 2);
        sclk = 1'b0; waitc(H);
    endtask

    // Full two-wire write; returns the three acknowledge bits.
    task automatic w2(input logic [7:0] dev, input logic [15:0] w, output logic [2:0] acks);
        bit a;
        int idx;
        idx = (w[15:9] < NREG) ? int'(w[15:9]) : 1;
        t_start();
        t_byte(dev, a, 1'b0, 0, 9'd0);      acks[2] = a;
        t_byte(w[15:8], a, 1'b0, 0, 9'd0);  acks[1] = a;
        t_byte(w[7:0], a, 1'b1, idx, model[idx]); acks[0] = a;
        t_stop();
    endtask

    task automatic model_write(input logic [15:0] w);
        if (w[15:9] == 0) model_reset();
        else if (w[15:9] < NREG) model[w[15:9]] = w[8:0];
    endtask

    initial begin
        logic [2:0] acks;
        bit a;
        model_reset();
        waitc(5);
        check_bank("R1 defaults under reset");
        rst_n = 1'b1;
        waitc(5);
        check_bank("R1 defaults after reset");
        check("R9 no pull after reset", 32'(pull), 0);

        // R2/R3: three-wire sweep over every non-zero address
        mode_2w = 1'b0; waitc(4);
        for (int i = 1; i < NREG; i++) begin
            logic [15:0] w;
            w = {7'(i), 9'((i * 113 + 77) % 512)};
            w3(16, 32'(w));
            model_write(w);
        end
        check_bank("R2 R3 three-wire sweep");

        // R3: wrong bit counts discarded
        w3(15, 32'({7'd5, 9'h155} >> 1));
        check_bank("R3 15-bit frame dropped");
        w3(17, {15'd0, 1'b1, 7'd6, 9'h0AA});
        check_bank("R3 17-bit frame dropped");

        // R8: out-of-range address
        w3(16, 32'({7'd100, 9'h1FF}));
        w3(16, 32'({7'd64, 9'h123}));
        check_bank("R8 high address ignored");

        // R7: reset address via three-wire
        w3(16, 32'({7'd0, 9'h1FF}));
        model_reset();
        check_bank("R7 soft reset three-wire");

        // R9: two-wire traffic in three-wire mode
        w2(8'h34, {7'd9, 9'h0F0}, acks);
        check("R9 no ack in three-wire mode", 32'(acks), 0);
        check_bank("R9 two-wire ignored in three-wire mode");

        // R4/R10: two-wire writes across an address sweep
        mode_2w = 1'b1; waitc(4);
        for (int i = 1; i < NREG; i += 5) begin
            logic [15:0] w;
            w = {7'(i), 9'((i * 59 + 300) % 512)};
            w2(8'h34, w, acks);
            check("R4 acks on all three bytes", 32'(acks), 32'h7);
            model_write(w);
        end
        w2(8'h34, {7'd2, 9'h100}, acks);   // bit 8 travels in the first byte
        model_write({7'd2, 9'h100});
        check_bank("R4 two-wire sweep");

        // R5: wrong device address and read request
        w2(8'h36, {7'd3, 9'h011}, acks);
        check("R5 wrong device no ack", 32'(acks), 0);
        w2(8'h35, {7'd3, 9'h011}, acks);
        check("R5 read bit no ack", 32'(acks), 0);
        check_bank("R5 no write");

        // R6: stop after the first data byte
        t_start();
        t_byte(8'h34, a, 1'b0, 0, 9'd0);
        t_byte({7'd4, 1'b1}, a, 1'b0, 0, 9'd0);
        check("R6 first byte acked", 32'(a), 1);
        t_stop();
        check_bank("R6 stop aborts write");

        // R9: three-wire traffic in two-wire mode
        w3(16, 32'({7'd7, 9'h0AB}));
        check_bank("R9 three-wire ignored in two-wire mode");

        // R8 and R7 through two-wire
        w2(8'h34, {7'd127, 9'h1AA}, acks);
        check_bank("R8 high address ignored two-wire");
        w2(8'h34, {7'd0, 9'h000}, acks);
        model_reset();
        check_bank("R7 soft reset two-wire");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule